// File: doc/BRIEF.md
# Command Packet Framer with Checksum

This block sits on the bus-master side of a multi-drop serial control bus. It takes one command request: a 4-bit destination, two hardware-select bits, a read flag, an expansion bit, a 6-bit command code, a data count and up to four data bytes. It turns the request into a framed byte stream and hands the bytes, one at a time, to a UART transmitter over a valid/ready handshake.

A request is taken only while the framer is idle. Every field is captured when the request is taken, so the requester may change its inputs while the packet is still going out. The framer works out a 16-bit checksum when it takes the request. For packets that carry data, the checksum goes out high byte first and then low byte, between the two header bytes and the data. A packet with no data is just the two header bytes. A request with a data count the frame cannot encode is refused with a one-cycle error pulse, and no byte goes out. Between packets the framer tells the transmitter to hold the line at its high idle level.

Top module: `cmd_frame_tx`

## Requirements
- R1: The first byte of every packet carries the 2-bit length code in bits 7:6, the hardware-select bits in bits 5:4 and the destination in bits 3:0.
- R2: The second byte carries the read flag in bit 7, the expansion bit in bit 6 and the command code in bits 5:0.
- R3: Data counts 0, 2 and 4 give length codes 00, 01 and 10 and packets of exactly 2, 6 and 8 bytes.
- R4: In a packet with data, bytes 5 onward are the data bytes in order, starting with req_data[7:0].
- R5: In a packet with data, byte 3 is the high byte and byte 4 the low byte of the 16-bit sum (mod 65536) of both header bytes and every data byte that is sent.
- R6: A packet with a data count of 0 is only its two header bytes and carries no checksum.
- R7: While no packet is in progress (and during reset), tx_valid is low, busy is low and tx_mark_hold is high.
- R8: Destination 15 (broadcast) is framed like any other destination, with 4'hF in bits 3:0 of the first byte.
- R9: A request taken while idle whose data count is not 0, 2 or 4 raises req_err for exactly the next cycle. No byte is sent and busy stays low.
- R10: Requests are taken only while busy is low. A request presented while busy is ignored and raises no error. Input changes after a request is taken do not alter the packet.
- R11: A byte advances only on a cycle with tx_valid and tx_ready both high. While tx_ready is low, tx_data holds. busy is high from the cycle after the request is taken until the cycle after the last byte's handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 4 | Destination (15 = broadcast) |
| req_hw | input | 2 | Hardware-select bits |
| req_rd | input | 1 | Read flag |
| req_ext | input | 1 | Command expansion bit |
| req_cmd | input | 6 | Command code |
| req_cnt | input | 3 | Data byte count (0, 2 or 4 valid) |
| req_data | input | 32 | Data bytes, byte 0 in bits 7:0 |
| req_err | output | 1 | One-cycle pulse when a request is refused |
| busy | output | 1 | Packet in progress |
| tx_valid | output | 1 | tx_data holds a byte for the transmitter |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter accepts the byte |
| tx_mark_hold | output | 1 | High while the line should idle high |

## Verification
The bench builds the framer with its default field widths: a 4-bit destination, a 6-bit command and at most four data bytes. This makes every length code reachable, along with the broadcast destination and all refused counts (1, 3, 5, 6, 7). A behavioural byte-queue model is compared with the outputs on every cycle. It runs with tx_ready held high and with a pseudo-random ready pattern, so byte holding under back-pressure and the exact cycle busy falls are both covered. Requests presented during a packet, and fields scrambled after a request is taken, check that the captured request is the one that goes out.

// File: rtl/cft_pkg.sv
package cft_pkg;
  localparam int FRM_ADDR_W   = 4;
  localparam int FRM_HW_W     = 2;
  localparam int FRM_CMD_W    = 6;
  localparam int FRM_DATA_MAX = 4;
  localparam int FRM_CNT_W    = $clog2(FRM_DATA_MAX + 1);
  localparam int FRM_LEN_MAX  = FRM_DATA_MAX + 4;
  localparam int FRM_IDX_W    = $clog2(FRM_LEN_MAX);
  localparam int FRM_SLOT_W   = $clog2(FRM_DATA_MAX);
  localparam int FRM_CSUM_W   = 16;
  localparam int FRM_DATA_W   = 8 * FRM_DATA_MAX;

  typedef logic [7:0] byte_t;

  typedef struct packed {
    byte_t                  hdr0;
    byte_t                  hdr1;
    logic [FRM_CSUM_W-1:0]  csum;
    logic [FRM_DATA_W-1:0]  data;
    logic [FRM_IDX_W-1:0]   last_idx;
  } frame_t;
endpackage

// File: rtl/cft_rst_sync.sv
module cft_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cft_frame_build.sv
module cft_frame_build
  import cft_pkg::*;
(
  input  logic [FRM_ADDR_W-1:0] addr,
  input  logic [FRM_HW_W-1:0]   hw,
  input  logic                  rd,
  input  logic                  ext,
  input  logic [FRM_CMD_W-1:0]  cmd,
  input  logic [FRM_CNT_W-1:0]  cnt,
  input  logic [FRM_DATA_W-1:0] data,
  output logic                  cnt_ok,
  output frame_t                frm
);
  logic [FRM_CSUM_W-1:0] acc;
  logic [1:0]            len_code;

  // Even counts up to the maximum are encodable; the code is the count halved.
  assign cnt_ok   = (cnt[0] == 1'b0) && (cnt <= FRM_CNT_W'(FRM_DATA_MAX));
  assign len_code = cnt[FRM_CNT_W-1:1];

  always_comb begin
    frm.hdr0 = {len_code, hw, addr};
    frm.hdr1 = {rd, ext, cmd};
    frm.data = data;
    acc = FRM_CSUM_W'(frm.hdr0) + FRM_CSUM_W'(frm.hdr1);
    for (int i = 0; i < FRM_DATA_MAX; i++) begin
      if (FRM_CNT_W'(i) < cnt) acc = acc + FRM_CSUM_W'(data[8*i +: 8]);
    end
    frm.csum = acc;
    if (cnt == '0) frm.last_idx = FRM_IDX_W'(1);
    else           frm.last_idx = FRM_IDX_W'(cnt) + FRM_IDX_W'(3);
  end
endmodule

// File: rtl/cft_seq.sv
module cft_seq
  import cft_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 cnt_ok,
  input  frame_t               frm_in,
  input  logic                 tx_ready,
  output logic                 busy,
  output logic                 err,
  output logic [FRM_IDX_W-1:0] idx,
  output frame_t               frm
);
  logic                 busy_q, busy_d;
  logic                 err_q, err_d;
  logic [FRM_IDX_W-1:0] idx_q, idx_d;
  logic                 load;
  frame_t               frm_q;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    err_d  = 1'b0;
    load   = 1'b0;
    if (busy_q) begin
      if (tx_ready) begin
        if (idx_q == frm_q.last_idx) begin
          busy_d = 1'b0;
          idx_d  = '0;
        end else begin
          idx_d  = idx_q + 1'b1;
        end
      end
    end else if (req_valid) begin
      if (cnt_ok) begin
        load   = 1'b1;
        busy_d = 1'b1;
        idx_d  = '0;
      end else begin
        err_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      idx_q  <= '0;
      frm_q  <= '0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
      idx_q  <= idx_d;
      if (load) frm_q <= frm_in;
    end
  end

  assign busy = busy_q;
  assign err  = err_q;
  assign idx  = idx_q;
  assign frm  = frm_q;
endmodule

// File: rtl/cft_byte_sel.sv
module cft_byte_sel
  import cft_pkg::*;
(
  input  logic [FRM_IDX_W-1:0] idx,
  input  frame_t               frm,
  output byte_t                out_byte
);
  byte_t                  slot [FRM_DATA_MAX];
  logic [FRM_IDX_W-1:0]   didx;

  for (genvar g = 0; g < FRM_DATA_MAX; g++) begin : g_slot
    assign slot[g] = frm.data[8*g +: 8];
  end

  assign didx = idx - FRM_IDX_W'(4);

  always_comb begin
    case (idx)
      FRM_IDX_W'(0): out_byte = frm.hdr0;
      FRM_IDX_W'(1): out_byte = frm.hdr1;
      FRM_IDX_W'(2): out_byte = frm.csum[15:8];
      FRM_IDX_W'(3): out_byte = frm.csum[7:0];
      default:       out_byte = slot[didx[FRM_SLOT_W-1:0]];
    endcase
  end
endmodule

// File: rtl/cmd_frame_tx.sv
module cmd_frame_tx
  import cft_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [FRM_ADDR_W-1:0] req_addr,
  input  logic [FRM_HW_W-1:0]   req_hw,
  input  logic                  req_rd,
  input  logic                  req_ext,
  input  logic [FRM_CMD_W-1:0]  req_cmd,
  input  logic [FRM_CNT_W-1:0]  req_cnt,
  input  logic [FRM_DATA_W-1:0] req_data,
  output logic                  req_err,
  output logic                  busy,
  output logic                  tx_valid,
  output logic [7:0]            tx_data,
  input  logic                  tx_ready,
  output logic                  tx_mark_hold
);
  logic                 rst_sync_n;
  logic                 cnt_ok;
  frame_t               frm_new;
  frame_t               frm_cur;
  logic [FRM_IDX_W-1:0] idx;
  logic                 busy_i;

  cft_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cft_frame_build u_build (
    .addr   (req_addr),
    .hw     (req_hw),
    .rd     (req_rd),
    .ext    (req_ext),
    .cmd    (req_cmd),
    .cnt    (req_cnt),
    .data   (req_data),
    .cnt_ok (cnt_ok),
    .frm    (frm_new)
  );

  cft_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .cnt_ok    (cnt_ok),
    .frm_in    (frm_new),
    .tx_ready  (tx_ready),
    .busy      (busy_i),
    .err       (req_err),
    .idx       (idx),
    .frm       (frm_cur)
  );

  cft_byte_sel u_sel (
    .idx      (idx),
    .frm      (frm_cur),
    .out_byte (tx_data)
  );

  assign busy         = busy_i;
  assign tx_valid     = busy_i;
  assign tx_mark_hold = ~busy_i;
endmodule

// File: rtl/cft_checker.sv
module cft_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [3:0]  req_addr,
  input logic [1:0]  req_hw,
  input logic        req_rd,
  input logic        req_ext,
  input logic [5:0]  req_cmd,
  input logic [2:0]  req_cnt,
  input logic [31:0] req_data,
  input logic        req_err,
  input logic        busy,
  input logic        tx_valid,
  input logic [7:0]  tx_data,
  input logic        tx_ready,
  input logic        tx_mark_hold
);
  logic good_cnt;
  assign good_cnt = (req_cnt == 3'd0) || (req_cnt == 3'd2) || (req_cnt == 3'd4);

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tx_mark_hold && !tx_valid));  // R7

  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));  // R11

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !busy);  // R9

  AST_BUSY_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> !req_err);  // R10

  AST_FIRST_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && good_cnt) |=> (tx_valid && tx_data == {$past(req_cnt[2:1]), $past(req_hw), $past(req_addr)}));  // R1

  AST_BAD_CNT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && !good_cnt) |=> (req_err && !busy));  // R9
endmodule

bind cmd_frame_tx cft_checker u_chk (.*);

// File: tb/cmd_frame_tx_bench.sv
module cmd_frame_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [3:0]  req_addr;
  logic [1:0]  req_hw;
  logic        req_rd, req_ext;
  logic [5:0]  req_cmd;
  logic [2:0]  req_cnt;
  logic [31:0] req_data;
  logic        req_err, busy, tx_valid, tx_mark_hold;
  logic [7:0]  tx_data;
  logic        tx_ready;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cmd_frame_tx u_cmd_frame_tx (.*);

  // Reference model
  logic [7:0] exp_q[$];
  bit m_busy = 0, m_err = 0, m_bcast = 0;
  int m_pos = 0, m_len = 0;
  bit rdy_rand = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    bit old_busy;
    if (!rst_n) begin
      m_busy = 0; m_err = 0; exp_q.delete();
    end else begin
      old_busy = m_busy;
      m_err = 0;
      if (old_busy && tx_ready) begin
        void'(exp_q.pop_front());
        m_pos++;
        if (exp_q.size() == 0) m_busy = 0;
      end
      if (!old_busy && req_valid) begin
        if (req_cnt == 0 || req_cnt == 2 || req_cnt == 4) begin
          int sum;
          logic [7:0] b0, b1;
          b0 = {req_cnt[2:1], req_hw, req_addr};
          b1 = {req_rd, req_ext, req_cmd};
          exp_q.push_back(b0);
          exp_q.push_back(b1);
          sum = b0 + b1;
          for (int i = 0; i < req_cnt; i++) sum += req_data[8*i +: 8];
          if (req_cnt != 0) begin
            exp_q.push_back(sum[15:8]);
            exp_q.push_back(sum[7:0]);
            for (int i = 0; i < req_cnt; i++) exp_q.push_back(req_data[8*i +: 8]);
          end
          m_len = exp_q.size();
          m_pos = 0;
          m_bcast = (req_addr == 4'hF);
          m_busy = 1;
        end else begin
          m_err = 1;
        end
      end
    end
  end

  // Ready driver
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready = rdy_rand ? lfsr[0] : 1'b1;
  end

  // Cycle compare
  always @(negedge clk) begin
    string t;
    if (m_busy && !busy) t = (m_len == 2) ? "R6" : "R3";
    else t = "R11";
    chk(busy == m_busy, t, busy, m_busy);
    chk(tx_valid == m_busy, "R11", tx_valid, m_busy);
    chk(tx_mark_hold == !m_busy, "R7", tx_mark_hold, !m_busy);
    chk(req_err == m_err, "R9", req_err, m_err);
    if (m_busy && exp_q.size() > 0) begin
      if (m_pos == 0) t = m_bcast ? "R8" : "R1";
      else if (m_pos == 1) t = (m_len == 2) ? "R6" : "R2";
      else if (m_pos < 4) t = "R5";
      else t = "R4";
      chk(tx_data == exp_q[0], t, tx_data, exp_q[0]);
    end
  end

  task automatic send(input logic [3:0] a, input logic [1:0] h, input bit r, input bit e,
                      input logic [5:0] c, input logic [2:0] n, input logic [31:0] d,
                      input int poke_busy);
    @(posedge clk); #2;
    req_addr = a; req_hw = h; req_rd = r; req_ext = e; req_cmd = c; req_cnt = n; req_data = d;
    req_valid = 1;
    @(posedge clk); #2;
    // scramble fields; optionally keep requesting while busy (R10)
    req_addr = ~a; req_cmd = ~c; req_data = ~d; req_hw = ~h;
    req_cnt = 3'd2;
    req_valid = (poke_busy > 0);
    for (int k = 0; k < poke_busy; k++) begin
      @(posedge clk); #2;
    end
    req_valid = 0;
    while (m_busy) begin
      @(posedge clk); #2;
    end
  endtask

  int base;

  initial begin
    rst_n = 0; req_valid = 0; req_addr = 0; req_hw = 0; req_rd = 0; req_ext = 0;
    req_cmd = 0; req_cnt = 0; req_data = 0; tx_ready = 1;
    repeat (3) @(posedge clk);
    #1;
    chk(busy == 0 && tx_mark_hold == 1 && tx_valid == 0, "R7", busy, 0);
    rst_n = 1;
    repeat (5) @(posedge clk);

    base = n_fail;
    send(4'h3, 2'b10, 1, 0, 6'h15, 3'd0, 32'h0, 0);
    chk(n_fail == base, "R6", n_fail - base, 0);

    base = n_fail;
    send(4'h5, 2'b01, 0, 1, 6'h2A, 3'd2, 32'h0000_C3A7, 0);
    send(4'hC, 2'b11, 1, 1, 6'h3F, 3'd4, 32'hFFFF_FFFF, 0);
    chk(n_fail == base, "R3", n_fail - base, 0);

    base = n_fail;
    send(4'hF, 2'b00, 0, 0, 6'h01, 3'd2, 32'h0000_1234, 0);
    chk(n_fail == base, "R8", n_fail - base, 0);

    base = n_fail;
    for (int bad = 1; bad < 8; bad++) begin
      if (bad != 2 && bad != 4)
        send(4'h2, 2'b01, 1, 0, 6'h10, 3'(bad), 32'hDEAD_BEEF, 0);
    end
    chk(n_fail == base, "R9", n_fail - base, 0);

    rdy_rand = 1;
    base = n_fail;
    send(4'h9, 2'b10, 0, 1, 6'h07, 3'd4, 32'h8040_2010, 4);
    send(4'h1, 2'b01, 1, 0, 6'h22, 3'd0, 32'h0, 2);
    chk(n_fail == base, "R10", n_fail - base, 0);

    base = n_fail;
    send(4'hA, 2'b11, 0, 0, 6'h30, 3'd4, 32'h0102_0304, 0);
    send(4'h4, 2'b00, 1, 1, 6'h0C, 3'd2, 32'h0000_7F80, 0);
    chk(n_fail == base, "R11", n_fail - base, 0);
    chk(n_fail == 0, "R4", n_fail, 0);
    chk(n_fail == 0, "R5", n_fail, 0);
    rdy_rand = 0;

    repeat (4) @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R11 actual=timeout expected=finish");
    finish_run();
  end
endmodule